// File: doc/BRIEF.md
# Transfer Byte Counter with Address Tracker

This block follows one data-phase transfer. Software programs how many bytes remain through a byte-wide register port. The count is 24 bits wide and is written one byte at a time. A separate load port seeds a 32-bit committed address. Every pulse on `byte_commit` means that one byte has really left or arrived, and is not just fetched ahead. On each such pulse the count drops by one and the committed address rises by one. The committed address therefore always names the next byte after the last one truly moved, however far a prefetching engine has run ahead.

The block holds two latched status flags. One reports that the count has reached zero. The other reports that a commit arrived at zero and the counter rolled over. Each flag is cleared by writing a one to its bit, and each has its own enable toward a single interrupt line. A control write zeroes the count. Reads are registered: the byte selected by `reg_raddr` is presented one clock later.

Register offsets: 0x0 to 0x2 hold the count, least significant byte at 0x0. Offset 0x4 is the status byte: bit 0 is done and bit 1 is wrap. Writing it clears flags. Offset 0x5 holds the interrupt enables, bit 0 for done and bit 1 for wrap. Offset 0x6 is the control byte: writing bit 0 as 1 zeroes the count, and the byte reads as 0. Offsets 0x8 to 0xB hold the committed address, least significant byte at 0x8, and are read-only. Every other offset reads 0.

Top module: `xfer_track_top`

## Requirements
- R1: While `rst` is high at a clock edge, the count, committed address, flags, enables, `irq_o` and `reg_rdata` all become 0.
- R2: A write to offset 0x0, 0x1 or 0x2 replaces that byte of the count (0x0 least significant), leaving the other bytes unchanged, and the value reads back at the same offset.
- R3: An effective commit lowers the count by exactly one, modulo 2^24.
- R4: An effective commit raises the committed address by one. The address reads at 0x8 to 0xB (0x8 least significant), and writes to those offsets change nothing.
- R5: `addr_load` sets the committed address to `addr_load_val` at the next edge, and it overrides an increment requested in the same cycle.
- R6: The done flag (status bit 0, `done_o`) is set at the edge after any cycle in which the count is zero. It then stays set until it is cleared.
- R7: A commit while the count is zero makes the count 0xFFFFFF and sets the wrap flag (status bit 1, `wrap_o`) at the same edge.
- R8: Writing offset 0x4 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A zero count re-sets done at that same edge.
- R9: `irq_o` is 1 exactly one clock after a cycle in which some flag and its enable bit (offset 0x5) are both 1.
- R10: Writing offset 0x6 with bit 0 set makes the count 0 at the next edge, and offset 0x6 reads 0.
- R11: In a cycle with a count byte write or a count clear, `byte_commit` is ignored: neither the count decrement nor the address increment happens.
- R12: `reg_rdata` after an edge equals the register at the offset `reg_raddr` held before that edge. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write offset |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 4 | Read offset |
| reg_rdata | output | 8 | Registered read data |
| byte_commit | input | 1 | One byte safely transferred |
| addr_load | input | 1 | Load committed address |
| addr_load_val | input | 32 | Committed address start value |
| done_o | output | 1 | Done flag |
| wrap_o | output | 1 | Wrap flag |
| irq_o | output | 1 | Registered interrupt |

## Verification
Three pairs of events can fall in the same cycle. A commit can coincide with a register write to a count byte or to the clear control. A commit can coincide with an address load. A status clear can coincide with a zero count. Directed steps drive each pair together and then read the count and the address back through the register port. The check is that the write won and the commit left no trace. Against an address load, the load value must survive while the count still drops. Against a status clear on a zero count, done must stay set. A random phase then overlaps these events freely. A behavioural model, updated on each rising edge, judges every output on the falling edge.

// File: rtl/xfer_track_pkg.sv
package xfer_track_pkg;
  // register offsets
  localparam int OFS_CNT   = 0;
  localparam int OFS_STAT  = 4;
  localparam int OFS_INTEN = 5;
  localparam int OFS_CTRL  = 6;
  localparam int OFS_CADDR = 8;
  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_WRAP = 1;
  localparam int ST_N    = 2;
  // control bit positions
  localparam int CTL_CLR = 0;
endpackage

// File: rtl/xfer_regif.sv
module xfer_regif
  import xfer_track_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 4,
  parameter int DW     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [REG_AW-1:0]     waddr,
  input  logic [DW-1:0]         wdata,
  input  logic [REG_AW-1:0]     raddr,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [ADDR_W-1:0]     caddr,
  input  logic [ST_N-1:0]       stat,
  output logic [CNT_W/DW-1:0]   cnt_byte_we,
  output logic                  cnt_clear,
  output logic [ST_N-1:0]       stat_clr,
  output logic [ST_N-1:0]       en_q,
  output logic [DW-1:0]         rdata_q
);
  localparam int CNT_BYTES  = CNT_W / DW;
  localparam int ADDR_BYTES = ADDR_W / DW;

  logic [DW-1:0] rd_nxt;

  // write decode, one strobe per count lane
  for (genvar g = 0; g < CNT_BYTES; g++) begin : g_lane_we
    assign cnt_byte_we[g] = we && (waddr == REG_AW'(OFS_CNT + g));
  end

  assign cnt_clear = we && (waddr == REG_AW'(OFS_CTRL)) && wdata[CTL_CLR];
  assign stat_clr  = (we && (waddr == REG_AW'(OFS_STAT))) ? wdata[ST_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (we && (waddr == REG_AW'(OFS_INTEN))) begin
      en_q <= wdata[ST_N-1:0];
    end
  end

  // read mux on registered state
  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (raddr == REG_AW'(OFS_CNT + i)) rd_nxt = cnt[DW*i +: DW];
    end
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (raddr == REG_AW'(OFS_CADDR + i)) rd_nxt = caddr[DW*i +: DW];
    end
    if (raddr == REG_AW'(OFS_STAT))  rd_nxt[ST_N-1:0] = stat;
    if (raddr == REG_AW'(OFS_INTEN)) rd_nxt[ST_N-1:0] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end
endmodule

// File: rtl/xfer_count.sv
module xfer_count #(
  parameter int CNT_W = 24,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W/DW-1:0] byte_we,
  input  logic [DW-1:0]       wdata,
  input  logic                clear,
  input  logic                commit,
  output logic [CNT_W-1:0]    count_q,
  output logic                commit_eff,
  output logic                rollover
);
  localparam int CNT_BYTES = CNT_W / DW;

  logic [CNT_W-1:0] dec;

  // register access wins over a commit in the same cycle
  assign commit_eff = commit && !(|byte_we) && !clear;
  assign rollover   = commit_eff && (count_q == '0);
  assign dec        = count_q - CNT_W'(1);

  for (genvar g = 0; g < CNT_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        count_q[DW*g +: DW] <= '0;
      end else if (byte_we[g]) begin
        count_q[DW*g +: DW] <= wdata;
      end else if (commit_eff) begin
        count_q[DW*g +: DW] <= dec[DW*g +: DW];
      end
    end
  end
endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (inc)  addr_q <= addr_q + ADDR_W'(1);
  end
endmodule

// File: rtl/xfer_status.sv
module xfer_status
  import xfer_track_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cnt_zero,
  input  logic            rollover,
  input  logic [ST_N-1:0] clr,
  input  logic [ST_N-1:0] en,
  output logic [ST_N-1:0] stat_q,
  output logic            irq_q
);
  logic [ST_N-1:0] set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[ST_DONE] = cnt_zero;
    set_vec[ST_WRAP] = rollover;
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= set_vec | (stat_q & ~clr);
      irq_q  <= |(stat_q & en);
    end
  end
endmodule

// File: rtl/xfer_track_top.sv
module xfer_track_top
  import xfer_track_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [DW-1:0]     reg_rdata,
  input  logic              byte_commit,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_load_val,
  output logic              done_o,
  output logic              wrap_o,
  output logic              irq_o
);
  localparam int CNT_BYTES = CNT_W / DW;

  logic [CNT_BYTES-1:0] cnt_byte_we;
  logic                 cnt_clear;
  logic [ST_N-1:0]      stat_clr;
  logic [ST_N-1:0]      en_q;
  logic [ST_N-1:0]      stat_q;
  logic [CNT_W-1:0]     count_q;
  logic [ADDR_W-1:0]    caddr_q;
  logic                 commit_eff;
  logic                 rollover;

  xfer_regif #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW), .DW(DW)) u_regif (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .cnt(count_q), .caddr(caddr_q), .stat(stat_q),
    .cnt_byte_we(cnt_byte_we), .cnt_clear(cnt_clear), .stat_clr(stat_clr),
    .en_q(en_q), .rdata_q(reg_rdata)
  );

  xfer_count #(.CNT_W(CNT_W), .DW(DW)) u_count (
    .clk(clk), .rst(rst), .byte_we(cnt_byte_we), .wdata(reg_wdata),
    .clear(cnt_clear), .commit(byte_commit), .count_q(count_q),
    .commit_eff(commit_eff), .rollover(rollover)
  );

  xfer_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(addr_load), .load_val(addr_load_val),
    .inc(commit_eff), .addr_q(caddr_q)
  );

  xfer_status u_status (
    .clk(clk), .rst(rst), .cnt_zero(count_q == '0), .rollover(rollover),
    .clr(stat_clr), .en(en_q), .stat_q(stat_q), .irq_q(irq_o)
  );

  assign done_o = stat_q[ST_DONE];
  assign wrap_o = stat_q[ST_WRAP];
endmodule

// File: rtl/xfer_track_chk.sv
module xfer_track_chk
  import xfer_track_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 4,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_waddr,
  input logic [DW-1:0]     reg_wdata,
  input logic              byte_commit,
  input logic              addr_load,
  input logic [ADDR_W-1:0] addr_load_val,
  input logic [CNT_W-1:0]  count_q,
  input logic [ADDR_W-1:0] caddr_q,
  input logic [ST_N-1:0]   en_q,
  input logic              done_o,
  input logic              wrap_o,
  input logic              irq_o
);
  localparam int CNT_BYTES = CNT_W / DW;

  logic cnt_wr, ctl_clr, eff;
  assign cnt_wr  = reg_we && (reg_waddr < REG_AW'(OFS_CNT + CNT_BYTES));
  assign ctl_clr = reg_we && (reg_waddr == REG_AW'(OFS_CTRL)) && reg_wdata[CTL_CLR];
  assign eff     = byte_commit && !cnt_wr && !ctl_clr;

  assert_dec_R3: assert property (@(posedge clk) disable iff (rst)
    eff |=> count_q == $past(count_q) - CNT_W'(1));

  assert_addr_inc_R4: assert property (@(posedge clk) disable iff (rst)
    (eff && !addr_load) |=> caddr_q == $past(caddr_q) + ADDR_W'(1));

  assert_addr_load_R5: assert property (@(posedge clk) disable iff (rst)
    addr_load |=> caddr_q == $past(addr_load_val));

  assert_done_R6: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0) |=> done_o);

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (eff && count_q == '0) |=> (wrap_o && (&count_q)));

  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == $past((done_o && en_q[ST_DONE]) || (wrap_o && en_q[ST_WRAP])));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    ctl_clr |=> count_q == '0);

  assert_ignore_R11: assert property (@(posedge clk) disable iff (rst)
    (byte_commit && (cnt_wr || ctl_clr) && !addr_load) |=> $stable(caddr_q));
endmodule

bind xfer_track_top xfer_track_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
  .reg_wdata(reg_wdata), .byte_commit(byte_commit), .addr_load(addr_load),
  .addr_load_val(addr_load_val), .count_q(count_q), .caddr_q(caddr_q),
  .en_q(en_q), .done_o(done_o), .wrap_o(wrap_o), .irq_o(irq_o)
);

// File: tb/sim_xfer_track_top.sv
module sim_xfer_track_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [7:0]  reg_rdata;
  logic        byte_commit = 1'b0;
  logic        addr_load = 1'b0;
  logic [31:0] addr_load_val = '0;
  logic        done_o, wrap_o, irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_track_top u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .byte_commit(byte_commit), .addr_load(addr_load),
    .addr_load_val(addr_load_val), .done_o(done_o), .wrap_o(wrap_o),
    .irq_o(irq_o)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_valid = 0;
  int unsigned m_cnt, m_addr;
  bit          m_done, m_wrap, m_irq;
  bit [1:0]    m_en;
  bit [7:0]    m_rd;

  function automatic bit [7:0] model_read(input int a);
    if (a >= 0 && a <= 2) return 8'((m_cnt >> (8*a)) & 255);
    if (a == 4) return {6'd0, m_wrap, m_done};
    if (a == 5) return {6'd0, m_en};
    if (a >= 8 && a <= 11) return 8'((m_addr >> (8*(a-8))) & 255);
    return 8'd0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cnt = 0; m_addr = 0; m_done = 0; m_wrap = 0; m_irq = 0; m_en = 0; m_rd = 0;
    end else begin
      bit cw, cc, eff, nd, nw;
      int wa;
      wa  = int'(reg_waddr);
      cw  = reg_we && wa <= 2;
      cc  = reg_we && wa == 6 && reg_wdata[0];
      eff = byte_commit && !cw && !cc;
      m_rd  = model_read(int'(reg_raddr));
      m_irq = (m_done && m_en[0]) || (m_wrap && m_en[1]);
      nd = (m_cnt == 0) || (m_done && !(reg_we && wa == 4 && reg_wdata[0]));
      nw = (eff && m_cnt == 0) || (m_wrap && !(reg_we && wa == 4 && reg_wdata[1]));
      m_done = nd; m_wrap = nw;
      if (reg_we && wa == 5) m_en = reg_wdata[1:0];
      if (cc) m_cnt = 0;
      else if (cw) m_cnt = (m_cnt & ~(32'hFF << (8*wa))) | (32'(reg_wdata) << (8*wa));
      else if (eff) m_cnt = (m_cnt + 32'hFFFFFF) & 32'hFFFFFF;
      if (addr_load) m_addr = addr_load_val;
      else if (eff) m_addr = m_addr + 1;
    end
    m_valid = 1;
  end

  function automatic string rd_tag(input int a);
    if (a <= 2) return "R3";
    if (a == 4) return "R6";
    if (a == 5) return "R9";
    if (a == 6) return "R10";
    if (a >= 8 && a <= 11) return "R4";
    return "R12";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_valid) begin
      chk(rd_tag(int'(reg_raddr)), int'(reg_rdata), int'(m_rd));
      chk("R6", int'(done_o), int'(m_done));
      chk("R7", int'(wrap_o), int'(m_wrap));
      chk("R9", int'(irq_o), int'(m_irq));
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic drive(input bit we, input int wa, input int wd,
                       input bit cm, input bit al, input int unsigned av);
    reg_we = we; reg_waddr = 4'(wa); reg_wdata = 8'(wd);
    byte_commit = cm; addr_load = al; addr_load_val = av;
    @(negedge clk);
    reg_we = 0; byte_commit = 0; addr_load = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    reg_raddr = 4'(a);
    @(negedge clk);
    chk(tag, int'(reg_rdata), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'(reg_rdata), 0);
    chk("R1", int'(done_o), 0);
    chk("R1", int'(wrap_o), 0);
    chk("R1", int'(irq_o), 0);
    rst = 0;
    idle();
    rd_chk(8, 0, "R1");
    // R2: load count 3
    drive(1, 0, 8'h03, 0, 0, 0);
    drive(1, 1, 8'h00, 0, 0, 0);
    drive(1, 2, 8'h00, 0, 0, 0);
    rd_chk(0, 8'h03, "R2");
    // R8: clear done while count nonzero
    drive(1, 4, 8'h01, 0, 0, 0);
    chk("R8", int'(done_o), 0);
    // R3: three commits reach zero
    repeat (3) drive(0, 0, 0, 1, 0, 0);
    rd_chk(0, 0, "R3");
    chk("R6", int'(done_o), 1);
    // R8: clear done while count is zero -> stays set
    drive(1, 4, 8'h01, 0, 0, 0);
    chk("R8", int'(done_o), 1);
    // R7: commit at zero rolls over
    drive(0, 0, 0, 1, 0, 0);
    chk("R7", int'(wrap_o), 1);
    rd_chk(0, 8'hFF, "R7");
    rd_chk(2, 8'hFF, "R7");
    rd_chk(8, 4, "R4");
    // R4: writes to address bytes are ignored
    drive(1, 8, 8'h77, 0, 0, 0);
    rd_chk(8, 4, "R4");
    // R8: zero bits have no effect, one bit clears
    drive(1, 4, 8'h00, 0, 0, 0);
    chk("R8", int'(wrap_o), 1);
    drive(1, 4, 8'h02, 0, 0, 0);
    chk("R8", int'(wrap_o), 0);
    // R9: interrupt follows enabled flag
    drive(1, 5, 8'h01, 0, 0, 0);
    idle();
    chk("R9", int'(irq_o), 1);
    drive(1, 4, 8'h01, 0, 0, 0);
    idle();
    chk("R9", int'(irq_o), 0);
    // R5: address load then commits
    drive(0, 0, 0, 0, 1, 32'h100000FF);
    repeat (2) drive(0, 0, 0, 1, 0, 0);
    rd_chk(8, 8'h01, "R5");
    rd_chk(9, 8'h01, "R5");
    rd_chk(11, 8'h10, "R5");
    // R5: load wins over increment, count still drops
    drive(0, 0, 0, 1, 1, 32'h00000020);
    rd_chk(8, 8'h20, "R5");
    rd_chk(0, 8'hFC, "R3");
    // R11: byte write with commit -> commit ignored
    drive(1, 1, 8'h55, 1, 0, 0);
    rd_chk(0, 8'hFC, "R11");
    rd_chk(1, 8'h55, "R11");
    rd_chk(8, 8'h20, "R11");
    // R10: clear with commit
    drive(1, 6, 8'h01, 1, 0, 0);
    rd_chk(0, 0, "R10");
    rd_chk(6, 0, "R10");
    rd_chk(8, 8'h20, "R11");
    // R12: unmapped offset reads zero
    rd_chk(15, 0, "R12");
    // random overlap phase, judged by the model every cycle
    for (int i = 0; i < 3000; i++) begin
      bit we, cm, al;
      we = ($urandom % 8) == 0;
      cm = ($urandom % 2) == 0;
      al = ($urandom % 32) == 0;
      reg_raddr = 4'($urandom);
      drive(we, int'($urandom % 16), int'($urandom % 256), cm, al,
            ($urandom % 4 == 0) ? 32'hFFFFFFFE : $urandom);
    end
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule